// File: doc/BRIEF.md
# Finite Automaton Language Equivalence Checker

This block decides whether two deterministic finite automata over the alphabet {0,1} accept exactly the same set of words. Each automaton has up to `N_STATES` states. Software-side logic loads both machines through a small write port: the successor of every state on input 0 and on input 1, a bitmask of accepting states, and the initial state.

A start pulse launches a multi-cycle check. Two cross machines are explored in parallel. The first pairs the complement of machine A with machine B, so it accepts the words that only B takes. The second pairs A with the complement of B, so it accepts the words that only A takes. Each cross machine begins at the pair of initial states. In every cycle it adds all one-step successors of the pairs already reached. Exploration ends when the reached set stops growing. A cross machine is non-empty when some reached pair is accepting in it. The machines are equivalent exactly when both cross machines are empty.

The result appears as a one-cycle `done_o` pulse together with `equiv_o`, `b_only_o` and `a_only_o`. These three flags hold their values until the next accepted start.

Top module: `dfa_equiv`

## Requirements
- R1: Asynchronous active-low reset clears both tables to zero, with all successors 0, no accepting states and initial state 0. It also clears busy_o, done_o, equiv_o, b_only_o and a_only_o.
- R2: A write with wr_en_i high while idle updates the machine chosen by wr_sel_i (0 = A, 1 = B). The entry is chosen by wr_kind_i: 0 sets the successor of state wr_idx_i on input 0; 1 sets the successor of state wr_idx_i on input 1; 2 sets the accepting mask, where bit i means that state i accepts; 3 sets the initial state. For kinds 0, 1 and 3 the value is taken from the low log2(N_STATES) bits of wr_data_i.
- R3: b_only_o is 1 after a check if and only if some word is accepted by B and rejected by A.
- R4: a_only_o is 1 after a check if and only if some word is accepted by A and rejected by B.
- R5: equiv_o is 1 after a check if and only if both b_only_o and a_only_o are 0.
- R6: The empty word counts. If exactly one machine's initial state accepts, the matching flag is set.
- R7: States that cannot be reached from the initial states, in either machine or in the product, have no effect on the result.
- R8: busy_o rises on the edge that samples start_i while idle. done_o is a single-cycle pulse on edge k+1 after that edge, where k is the number of expansion steps the slower cross machine needs before its reached set stops growing. busy_o falls on that same edge.
- R9: While busy_o is high, start_i and table writes are ignored. The flags are cleared when a check starts and then hold from done_o until the next accepted start.
- R10: Two machines with no accepting states are equivalent, whatever their successor tables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 1 | Target machine: 0 = A, 1 = B |
| wr_kind_i | input | 2 | Entry kind: 0 succ-on-0, 1 succ-on-1, 2 accept mask, 3 initial state |
| wr_idx_i | input | log2(N_STATES) | State whose successor is written |
| wr_data_i | input | N_STATES | Write value |
| start_i | input | 1 | Begin a check (ignored while busy) |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| equiv_o | output | 1 | Languages are equal |
| b_only_o | output | 1 | Some word is accepted by B and not by A |
| a_only_o | output | 1 | Some word is accepted by A and not by B |

## Verification
Once the edge that samples start_i has passed, `busy_o` is already high at the next falling edge. `done_o` is due exactly k+1 rising edges later, where k is the count of growth steps for the slower cross machine. The bench derives k by running its own breadth-first expansion over its model of the loaded tables. It then counts rising edges and samples on falling edges. It checks that done arrives on exactly that edge, that the flags are correct in that cycle, and that one cycle later done has dropped and the flags are unchanged. The writes and the second start issued while busy are checked by repeating the check afterwards and comparing with the model of the tables as they were before those writes.

// File: rtl/dfa_eq_pkg.sv
`timescale 1ns/1ps
package dfa_eq_pkg;
  typedef enum logic [1:0] {
    WK_NEXT0 = 2'd0,
    WK_NEXT1 = 2'd1,
    WK_FINAL = 2'd2,
    WK_START = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/dfa_table.sv
`timescale 1ns/1ps
module dfa_table
  import dfa_eq_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  wr_kind_e             kind_i,
  input  logic [SW-1:0]        idx_i,
  input  logic [N-1:0]         data_i,
  output logic [N-1:0][SW-1:0] nxt0_o,
  output logic [N-1:0][SW-1:0] nxt1_o,
  output logic [N-1:0]         fin_o,
  output logic [SW-1:0]        start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt0_o  <= '0;
      nxt1_o  <= '0;
      fin_o   <= '0;
      start_o <= '0;
    end else if (we_i) begin
      unique case (kind_i)
        WK_NEXT0: nxt0_o[idx_i] <= data_i[SW-1:0];
        WK_NEXT1: nxt1_o[idx_i] <= data_i[SW-1:0];
        WK_FINAL: fin_o         <= data_i;
        WK_START: start_o       <= data_i[SW-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/prod_explore.sv
`timescale 1ns/1ps
module prod_explore #(
  parameter int N           = 8,
  parameter int SW          = $clog2(N),
  parameter bit COMPL_FIRST = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 run_i,
  input  logic [N-1:0][SW-1:0] a_nxt0_i,
  input  logic [N-1:0][SW-1:0] a_nxt1_i,
  input  logic [N-1:0]         a_fin_i,
  input  logic [SW-1:0]        a_start_i,
  input  logic [N-1:0][SW-1:0] b_nxt0_i,
  input  logic [N-1:0][SW-1:0] b_nxt1_i,
  input  logic [N-1:0]         b_fin_i,
  input  logic [SW-1:0]        b_start_i,
  output logic                 conv_o,
  output logic                 hit_o
);
  localparam int P  = N * N;
  localparam int PW = 2 * SW;

  function automatic logic [PW-1:0] pidx(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return PW'(a) * PW'(N) + PW'(b);
  endfunction

  logic [P-1:0] reach_q, reach_nxt, pfin;
  logic [N-1:0] fa_eff, fb_eff;

  // complement swaps accepting states; initial state is unchanged
  assign fa_eff = COMPL_FIRST ? ~a_fin_i : a_fin_i;
  assign fb_eff = COMPL_FIRST ? b_fin_i  : ~b_fin_i;

  for (genvar i = 0; i < N; i++) begin : g_fa
    for (genvar j = 0; j < N; j++) begin : g_fb
      assign pfin[i*N+j] = fa_eff[i] & fb_eff[j];
    end
  end

  always_comb begin
    reach_nxt = reach_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (reach_q[i*N+j]) begin
          reach_nxt[pidx(a_nxt0_i[i], b_nxt0_i[j])] = 1'b1;
          reach_nxt[pidx(a_nxt1_i[i], b_nxt1_i[j])] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reach_q <= '0;
    else if (load_i) reach_q <= {{(P-1){1'b0}}, 1'b1} << pidx(a_start_i, b_start_i);
    else if (run_i)  reach_q <= reach_nxt;
  end

  assign conv_o = (reach_nxt == reach_q);
  assign hit_o  = |(reach_q & pfin);
endmodule

// File: rtl/dfa_equiv.sv
`timescale 1ns/1ps
module dfa_equiv
  import dfa_eq_pkg::*;
#(
  parameter  int N_STATES = 8,
  localparam int SW       = $clog2(N_STATES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [1:0]          wr_kind_i,
  input  logic [SW-1:0]       wr_idx_i,
  input  logic [N_STATES-1:0] wr_data_i,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                equiv_o,
  output logic                b_only_o,
  output logic                a_only_o
);
  logic [N_STATES-1:0][SW-1:0] t_nxt0 [2];
  logic [N_STATES-1:0][SW-1:0] t_nxt1 [2];
  logic [N_STATES-1:0]         t_fin  [2];
  logic [SW-1:0]               t_st   [2];
  logic [1:0]                  conv, hit;
  logic                        busy_q, done_q, equiv_q;
  logic [1:0]                  only_q;
  logic                        load;

  assign load = start_i & ~busy_q;

  for (genvar m = 0; m < 2; m++) begin : g_tab
    dfa_table #(.N(N_STATES), .SW(SW)) u_tab (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i & ~busy_q & (wr_sel_i == 1'(m))),
      .kind_i  (wr_kind_e'(wr_kind_i)),
      .idx_i   (wr_idx_i),
      .data_i  (wr_data_i),
      .nxt0_o  (t_nxt0[m]),
      .nxt1_o  (t_nxt1[m]),
      .fin_o   (t_fin[m]),
      .start_o (t_st[m])
    );
  end

  // d=0: ~A x B (B-only words); d=1: A x ~B (A-only words)
  for (genvar d = 0; d < 2; d++) begin : g_dir
    prod_explore #(.N(N_STATES), .SW(SW), .COMPL_FIRST(d == 0)) u_exp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .run_i     (busy_q),
      .a_nxt0_i  (t_nxt0[0]),
      .a_nxt1_i  (t_nxt1[0]),
      .a_fin_i   (t_fin[0]),
      .a_start_i (t_st[0]),
      .b_nxt0_i  (t_nxt0[1]),
      .b_nxt1_i  (t_nxt1[1]),
      .b_fin_i   (t_fin[1]),
      .b_start_i (t_st[1]),
      .conv_o    (conv[d]),
      .hit_o     (hit[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      equiv_q <= 1'b0;
      only_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      equiv_q <= 1'b0;
      only_q  <= '0;
    end else if (busy_q && (&conv)) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      only_q  <= hit;
      equiv_q <= ~|hit;
    end else begin
      done_q  <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign equiv_o  = equiv_q;
  assign b_only_o = only_q[0];
  assign a_only_o = only_q[1];
endmodule

// File: rtl/dfa_equiv_chk.sv
`timescale 1ns/1ps
module dfa_equiv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic equiv_o,
  input logic b_only_o,
  input logic a_only_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_busy_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_equiv_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (equiv_o == !(a_only_o || b_only_o)));

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> $stable({equiv_o, b_only_o, a_only_o}));

  p_busy_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(equiv_o || b_only_o || a_only_o || done_o));
endmodule

bind dfa_equiv dfa_equiv_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .equiv_o  (equiv_o),
  .b_only_o (b_only_o),
  .a_only_o (a_only_o)
);

// File: tb/dfa_equiv_bench.sv
`timescale 1ns/1ps
module dfa_equiv_bench;
  localparam int N  = 8;
  localparam int SW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [1:0]    wr_kind_i = '0;
  logic [SW-1:0] wr_idx_i = '0;
  logic [N-1:0]  wr_data_i = '0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, equiv_o, b_only_o, a_only_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // model of the loaded tables
  int        m_n0 [2][N];
  int        m_n1 [2][N];
  bit [N-1:0] m_fin [2];
  int        m_st [2];

  always #5 clk_i = ~clk_i;

  dfa_equiv #(.N_STATES(N)) u_dfa_equiv (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic raw_wr(input int m, input int kind, input int idx, input int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'(m); wr_kind_i = 2'(kind);
    wr_idx_i = SW'(idx); wr_data_i = N'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_next(input int m, input int s, input int n0, input int n1);
    raw_wr(m, 0, s, n0); m_n0[m][s] = n0;
    raw_wr(m, 1, s, n1); m_n1[m][s] = n1;
  endtask

  task automatic set_fin(input int m, input int mask);
    raw_wr(m, 2, 0, mask); m_fin[m] = N'(mask);
  endtask

  task automatic set_start(input int m, input int s);
    raw_wr(m, 3, 0, s); m_st[m] = s;
  endtask

  task automatic clear_all();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < N; s++) set_next(m, s, 0, 0);
      set_fin(m, 0);
      set_start(m, 0);
    end
  endtask

  // independent breadth-first expansion; d=0 counts B-only words, d=1 A-only
  task automatic ref_dir(input int d, output int steps, output bit hit);
    logic [N*N-1:0] r, rn;
    r = '0; r[m_st[0]*N + m_st[1]] = 1'b1; steps = 0;
    forever begin
      rn = r;
      for (int p = 0; p < N*N; p++)
        if (r[p]) begin
          rn[m_n0[0][p/N]*N + m_n0[1][p%N]] = 1'b1;
          rn[m_n1[0][p/N]*N + m_n1[1][p%N]] = 1'b1;
        end
      if (rn == r) break;
      r = rn; steps++;
    end
    hit = 1'b0;
    for (int p = 0; p < N*N; p++)
      if (r[p]) begin
        if (d == 0 && !m_fin[0][p/N] &&  m_fin[1][p%N]) hit = 1'b1;
        if (d == 1 &&  m_fin[0][p/N] && !m_fin[1][p%N]) hit = 1'b1;
      end
  endtask

  task automatic run_check(input string req);
    int s0, s1, lat, k;
    bit h0, h1;
    ref_dir(0, s0, h0);
    ref_dir(1, s1, h1);
    lat = ((s0 > s1) ? s0 : s1) + 1;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
    k = 0;
    do begin
      @(negedge clk_i); k++;
    end while (!done_o && k < 200);
    chk(k == lat, "R8", "done latency", k, lat);
    chk(b_only_o == h0, {req, " R3"}, "b_only", b_only_o, h0);
    chk(a_only_o == h1, {req, " R4"}, "a_only", a_only_o, h1);
    chk(equiv_o == !(h0 || h1), {req, " R5"}, "equiv", equiv_o, !(h0 || h1));
    chk(busy_o == 1'b0, "R8", "busy at done", busy_o, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8", "done one cycle", done_o, 0);
    chk({equiv_o, b_only_o, a_only_o} == {!(h0 || h1), h0, h1}, "R9", "flags hold",
        {equiv_o, b_only_o, a_only_o}, {!(h0 || h1), h0, h1});
  endtask

  task automatic ends_with_one(input int m);
    set_next(m, 0, 0, 1); set_next(m, 1, 0, 1);
    set_fin(m, 'h02); set_start(m, 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && done_o == 0, "R1", "busy/done after reset", {busy_o, done_o}, 0);
    chk({equiv_o, b_only_o, a_only_o} == 0, "R1", "flags after reset",
        {equiv_o, b_only_o, a_only_o}, 0);
    run_check("R1 cleared tables");
  endtask

  task automatic t_same();
    clear_all(); ends_with_one(0); ends_with_one(1);
    run_check("R2 identical");
  endtask

  task automatic t_redundant();
    clear_all(); ends_with_one(0);
    set_next(0, 6, 6, 6); set_fin(0, 'h42);      // A state 6 accepts, unreachable
    set_next(1, 0, 0, 1); set_next(1, 1, 0, 2); set_next(1, 2, 0, 1);
    set_next(1, 5, 5, 5); set_fin(1, 'h26); set_start(1, 0);
    run_check("R7 unreachable");
  endtask

  task automatic t_superset();
    clear_all(); ends_with_one(0);
    set_next(1, 0, 0, 0); set_fin(1, 'h01); set_start(1, 0);
    run_check("R6 B superset");
  endtask

  task automatic t_swap();
    clear_all(); ends_with_one(1);
    set_next(0, 0, 0, 0); set_fin(0, 'h01); set_start(0, 0);
    run_check("R4 A superset");
  endtask

  task automatic t_eps();
    clear_all();
    set_next(0, 0, 1, 1); set_next(0, 1, 1, 1); set_fin(0, 'h01); set_start(0, 0);
    set_next(1, 2, 3, 2); set_start(1, 2);
    run_check("R6 empty word");
  endtask

  task automatic t_counter();
    clear_all();
    for (int s = 0; s < N; s++) set_next(0, s, s, (s + 1) % 8);
    for (int s = 0; s < 4; s++) set_next(1, s, s, (s + 1) % 4);
    set_fin(0, 'h01); set_fin(1, 'h01);
    run_check("R3 counters");
  endtask

  task automatic t_busy();
    bit [2:0] held;
    // counters still loaded; writes and restart during busy must be dropped
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    raw_wr(1, 2, 0, 'hFF);
    raw_wr(0, 3, 0, 5);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk(b_only_o == 1 && a_only_o == 0, "R9", "result during busy writes",
        {b_only_o, a_only_o}, 2);
    held = {equiv_o, b_only_o, a_only_o};
    repeat (6) @(negedge clk_i);
    chk({equiv_o, b_only_o, a_only_o} == held, "R9", "flags held idle",
        {equiv_o, b_only_o, a_only_o}, held);
    run_check("R9 writes ignored");
  endtask

  task automatic t_no_finals();
    clear_all();
    for (int s = 0; s < N; s++) begin
      set_next(0, s, (s + 3) % 8, (s + 5) % 8);
      set_next(1, s, (7 - s), (s * 3) % 8);
    end
    set_start(0, 2); set_start(1, 6);
    run_check("R10 no accepting");
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < N; s++) begin m_n0[m][s] = 0; m_n1[m][s] = 0; end
      m_fin[m] = '0; m_st[m] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_same();
    t_redundant();
    t_superset();
    t_swap();
    t_eps();
    t_counter();
    t_busy();
    t_no_finals();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule